// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external 512K x 8 asynchronous static RAM. The host raises a request with an address, a read/write flag and, for writes, a data byte. It holds that request until the controller answers with a one-cycle ready pulse; read data is valid in the same cycle as that pulse. On the memory side the controller drives 19 address lines and three active-low strobes: chip select, write enable and output enable. The 8-bit shared data bus is split into an output, an output enable and an input.

The memory's minimum timing limits are given in picoseconds as parameters, together with the clock period. Each interval becomes a cycle count by ceiling division, and every count is at least one cycle. All strobes and the data-bus enable are driven straight from flops. A turnaround gap follows every access, so the controller and the memory never drive the data bus at the same time.

The sequencer is a state machine with six states:
- `ST_IDLE` waits for a request.
- A request with the write flag set moves to `ST_WR_SETUP`. This state selects the chip, presents the address and starts driving data.
- `ST_WR_SETUP` always moves to `ST_WR_PULSE`, which holds write enable low for the write-pulse count.
- When that count runs out, the machine moves to `ST_WR_HOLD`. Here write enable is high again, while chip select stays low and data stays driven.
- `ST_WR_HOLD` always moves to `ST_GAP`.
- A request with the write flag clear moves from `ST_IDLE` to `ST_RD_ACCESS`. This state holds chip select and output enable low for the read-access count.
- When the read count runs out, the data is captured and the machine moves to `ST_GAP`.
- `ST_GAP` deselects the memory and releases the bus for the turnaround count, then returns to `ST_IDLE`.

Top module: `asram_ctrl`

## Requirements
- R1: A synchronous reset, including one applied in the middle of an access, drives chip select, write enable and output enable high, the data-bus enable low and ready low, and returns the controller to idle.
- R2: Write enable is low only while chip select is low. Output enable is low only while chip select is low and write enable is high.
- R3: Each write holds write enable low for exactly WP cycles. WP is the largest of ceil(write pulse / clock), ceil(data setup / clock) and ceil(write cycle / clock) minus 2, and is never less than 1; with the defaults it is 2. The address is held steady for as long as chip select stays low.
- R4: The data bus is driven from the cycle before write enable falls through the cycle in which it rises again. Its value does not change while it is driven.
- R5: Each read holds output enable low for exactly RD cycles, where RD = max(ceil(address access / clock), ceil(output-enable access / clock)), never less than 1; with the defaults it is 3. The byte on the data input at the clock edge that ends the read is returned on the read-data output.
- R6: A read from an address returns the byte most recently written there, including at the lowest address (0) and the highest address (all ones).
- R7: After the data-bus enable falls, output enable cannot fall until at least TURN cycles have passed, where TURN = ceil(turnaround / clock) and is never less than 1. After output enable rises, the data-bus enable cannot rise until at least TURN cycles have passed. The controller never drives the bus while the memory is in read mode.
- R8: A request is taken only in idle. Host address, write data and write flag are latched when the request is taken. Changes to them while an access is under way have no effect on that access.
- R9: Ready is a pulse exactly one cycle wide. Counting the edge that takes the request, it comes WP+3 clock edges later for a write and RD+1 clock edges later for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request, held until ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Byte address |
| host_wdata | input | 8 | Byte to write |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Byte returned by the last read |
| sram_addr | output | 19 | Memory address lines |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dout | output | 8 | Data driven toward the memory |
| sram_dout_en | output | 1 | 1 = controller drives the data bus |
| sram_din | input | 8 | Data bus as seen at the pins |

## Verification
With the defaults, a write answers with ready five clock edges after the edge that takes the request, and a read answers four edges after it. Write enable stays low for two cycles, output enable stays low for three, and each turnaround lasts at least one cycle. Each access task in the bench counts rising edges from the request to the first falling-edge sample that shows ready, and compares that count with the figure derived from the timing parameters. Pulse widths and bus gaps are counted at rising edges from the pin values of the cycle that is ending. Read data is compared at the falling edge of the cycle in which ready is high, which is the cycle after the capture edge.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_GAP
    } ctrl_state_e;

    // Whole clock cycles covering an interval, never fewer than one.
    function automatic int unsigned span_cycles(int unsigned t_ps, int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Cycles left for the pulse once setup and hold cycles are subtracted.
    function automatic int unsigned minus_two(int unsigned c);
        return (c > 2) ? c - 2 : 1;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3 R5: a loaded count reaches zero only after counting down.
    p_load_counts_r3: assert property (@(posedge clk) disable iff (rst)
        (load && value != '0) |=> !expired);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int unsigned WP_CYC   = 2,
    parameter int unsigned RD_CYC   = 3,
    parameter int unsigned TURN_CYC = 1,
    parameter int unsigned CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_req,
    input  logic             host_we,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_value,
    output logic             accept,
    output logic             rd_capture,
    output logic             cs_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             dout_en,
    output logic             ready
);

    localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

    ctrl_state_e state_q;
    ctrl_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and interval timer loads.
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_value = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    if (host_we) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d   = ST_RD_ACCESS;
                        tmr_load  = 1'b1;
                        tmr_value = RD_LOAD;
                    end
                end
            end
            ST_WR_SETUP: begin
                state_d   = ST_WR_PULSE;
                tmr_load  = 1'b1;
                tmr_value = WP_LOAD;
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_d = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                state_d   = ST_GAP;
                tmr_load  = 1'b1;
                tmr_value = TURN_LOAD;
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) begin
                    state_d   = ST_GAP;
                    tmr_load  = 1'b1;
                    tmr_value = TURN_LOAD;
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign accept     = (state_q == ST_IDLE) && host_req;
    assign rd_capture = (state_q == ST_RD_ACCESS) && tmr_expired;

    // Pin outputs registered from the next state so they never glitch.
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n    <= 1'b1;
            we_n    <= 1'b1;
            oe_n    <= 1'b1;
            dout_en <= 1'b0;
            ready   <= 1'b0;
        end else begin
            cs_n    <= !(state_d == ST_WR_SETUP || state_d == ST_WR_PULSE ||
                         state_d == ST_WR_HOLD  || state_d == ST_RD_ACCESS);
            we_n    <= (state_d != ST_WR_PULSE);
            oe_n    <= (state_d != ST_RD_ACCESS);
            dout_en <= (state_d == ST_WR_SETUP || state_d == ST_WR_PULSE ||
                        state_d == ST_WR_HOLD);
            ready   <= (state_q == ST_WR_HOLD) || rd_capture;
        end
    end

    p_we_needs_cs_r2: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !cs_n);

    p_oe_read_mode_r2: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (!cs_n && we_n));

    p_ready_single_r9: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    p_accept_idle_r8: assert property (@(posedge clk) disable iff (rst)
        accept |=> !cs_n);

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              rd_capture,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] sram_din,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dout,
    output logic [DATA_W-1:0] host_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sram_addr  <= '0;
            sram_dout  <= '0;
            host_rdata <= '0;
        end else begin
            if (accept) begin
                sram_addr <= host_addr;
                sram_dout <= host_wdata;
            end
            if (rd_capture) begin
                host_rdata <= sram_din;
            end
        end
    end

    p_rdata_held_r5: assert property (@(posedge clk) disable iff (rst)
        !rd_capture |=> $stable(host_rdata));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_PS    = 8000,
    parameter int unsigned T_WP_PS   = 14000,
    parameter int unsigned T_DS_PS   = 9000,
    parameter int unsigned T_WC_PS   = 20000,
    parameter int unsigned T_AA_PS   = 20000,
    parameter int unsigned T_OE_PS   = 10000,
    parameter int unsigned T_TURN_PS = 6000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dout,
    output logic              sram_dout_en,
    input  logic [DATA_W-1:0] sram_din
);

    localparam int unsigned WP_CYC = max2(max2(span_cycles(T_WP_PS, CLK_PS),
                                               span_cycles(T_DS_PS, CLK_PS)),
                                          minus_two(span_cycles(T_WC_PS, CLK_PS)));
    localparam int unsigned RD_CYC = max2(span_cycles(T_AA_PS, CLK_PS),
                                          span_cycles(T_OE_PS, CLK_PS));
    localparam int unsigned TURN_CYC = span_cycles(T_TURN_PS, CLK_PS);
    localparam int unsigned MAX_CYC  = max2(max2(WP_CYC, RD_CYC), TURN_CYC);
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1) + 1;
    localparam int unsigned CK_W     = $clog2(MAX_CYC + 2) + 1;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_value;
    logic             tmr_expired;
    logic             accept;
    logic             rd_capture;

    asram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .value   (tmr_value),
        .expired (tmr_expired)
    );

    asram_fsm #(
        .WP_CYC   (WP_CYC),
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .host_req    (host_req),
        .host_we     (host_we),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_value   (tmr_value),
        .accept      (accept),
        .rd_capture  (rd_capture),
        .cs_n        (sram_cs_n),
        .we_n        (sram_we_n),
        .oe_n        (sram_oe_n),
        .dout_en     (sram_dout_en),
        .ready       (host_ready)
    );

    asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .rd_capture (rd_capture),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .sram_din   (sram_din),
        .sram_addr  (sram_addr),
        .sram_dout  (sram_dout),
        .host_rdata (host_rdata)
    );

    // Pin-level window counters used by the checks below.
    logic [CK_W-1:0] we_low_q;
    logic [CK_W-1:0] oe_low_q;
    logic [CK_W-1:0] drv_off_q;
    logic [CK_W-1:0] rd_off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_q  <= '0;
            oe_low_q  <= '0;
            drv_off_q <= CK_W'(TURN_CYC);
            rd_off_q  <= CK_W'(TURN_CYC);
        end else begin
            we_low_q <= sram_we_n ? '0 : we_low_q + 1'b1;
            oe_low_q <= sram_oe_n ? '0 : oe_low_q + 1'b1;
            if (sram_dout_en) begin
                drv_off_q <= '0;
            end else if (drv_off_q < CK_W'(TURN_CYC)) begin
                drv_off_q <= drv_off_q + 1'b1;
            end
            if (!sram_oe_n) begin
                rd_off_q <= '0;
            end else if (rd_off_q < CK_W'(TURN_CYC)) begin
                rd_off_q <= rd_off_q + 1'b1;
            end
        end
    end

    p_we_width_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (we_low_q == CK_W'(WP_CYC)));

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    p_data_before_we_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> $past(sram_dout_en));

    p_data_after_we_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> sram_dout_en);

    p_data_steady_r4: assert property (@(posedge clk) disable iff (rst)
        (sram_dout_en && $past(sram_dout_en)) |-> $stable(sram_dout));

    p_oe_width_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> (oe_low_q == CK_W'(RD_CYC)));

    p_gap_before_read_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_oe_n) |-> (drv_off_q >= CK_W'(TURN_CYC)));

    p_gap_before_write_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_dout_en) |-> (rd_off_q >= CK_W'(TURN_CYC)));

    p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
        sram_dout_en |-> sram_oe_n);

endmodule

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;

    localparam int CLK_PS = 8000;
    // Expected counts from the default limits, ceiling division.
    localparam int WP_EXP   = 2;   // ceil(14000/8000)=2, ceil(9000/8000)=2, ceil(20000/8000)-2=1
    localparam int RD_EXP   = 3;   // ceil(20000/8000)=3, ceil(10000/8000)=2
    localparam int TURN_EXP = 1;   // ceil(6000/8000)=1
    localparam int WR_LAT   = WP_EXP + 3;
    localparam int RD_LAT   = RD_EXP + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [18:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready;
    logic [7:0]  host_rdata;
    logic [18:0] sram_addr;
    logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dout_en;
    logic [7:0]  sram_dout;
    logic [7:0]  din_r = 8'hzz;

    always #4 clk = ~clk;

    asram_ctrl i_asram_ctrl (
        .clk          (clk),
        .rst          (rst),
        .host_req     (host_req),
        .host_we      (host_we),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_ready   (host_ready),
        .host_rdata   (host_rdata),
        .sram_addr    (sram_addr),
        .sram_cs_n    (sram_cs_n),
        .sram_we_n    (sram_we_n),
        .sram_oe_n    (sram_oe_n),
        .sram_dout    (sram_dout),
        .sram_dout_en (sram_dout_en),
        .sram_din     (din_r)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int contention = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Memory model.
    logic [7:0] sram_mem [int unsigned];
    logic [7:0] shadow   [int unsigned];

    always @(posedge clk) begin
        if (!sram_cs_n && !sram_we_n && sram_dout_en)
            sram_mem[32'(sram_addr)] = sram_dout;
    end

    always @(negedge clk) begin
        if (!sram_cs_n && !sram_oe_n && sram_we_n) begin
            din_r <= sram_mem.exists(32'(sram_addr)) ? sram_mem[32'(sram_addr)] : 8'hxx;
            if (sram_dout_en) contention++;
        end else begin
            din_r <= 8'hzz;
        end
    end

    // Pulse-width and turnaround monitor (values of the cycle ending at the edge).
    int  we_low = 0;
    int  oe_low = 0;
    int  drv_off = 100;
    bit  prev_oe_n = 1'b1;

    always @(posedge clk) begin
        if (rst) begin
            we_low = 0; oe_low = 0; drv_off = 100; prev_oe_n = 1'b1;
        end else begin
            if (!sram_we_n) we_low++;
            else if (we_low != 0) begin
                check(we_low == WP_EXP, "R3 write pulse width", we_low, WP_EXP);
                we_low = 0;
            end
            if (!sram_oe_n) oe_low++;
            else if (oe_low != 0) begin
                check(oe_low == RD_EXP, "R5 read strobe width", oe_low, RD_EXP);
                oe_low = 0;
            end
            if (!sram_oe_n && prev_oe_n)
                check(drv_off >= TURN_EXP, "R7 bus released before read", drv_off, TURN_EXP);
            drv_off   = sram_dout_en ? 0 : drv_off + 1;
            prev_oe_n = sram_oe_n;
        end
    end

    // Scoreboard.
    typedef struct packed {
        logic        is_rd;
        logic [18:0] addr;
        logic [7:0]  data;
    } exp_t;
    exp_t sb_q[$];

    always @(negedge clk) begin
        if (!rst && host_ready) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9 unexpected ready", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.is_rd)
                    check(host_rdata === e.data, "R6 read data", int'(host_rdata), int'(e.data));
            end
        end
    end

    task automatic do_op(input bit wr, input logic [18:0] addr, input logic [7:0] data,
                         input bit scramble);
        exp_t e;
        int n;
        e.is_rd = !wr;
        e.addr  = addr;
        e.data  = wr ? data : shadow[32'(addr)];
        if (wr) shadow[32'(addr)] = data;
        sb_q.push_back(e);
        host_we    = wr;
        host_addr  = addr;
        host_wdata = data;
        host_req   = 1'b1;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (scramble && n == 1) begin
                host_addr  = addr ^ 19'h1;
                host_wdata = ~data;
                host_we    = !wr;
            end
        end while (!host_ready && n < 40);
        check(n == (wr ? WR_LAT : RD_LAT), wr ? "R9 write latency" : "R9 read latency",
              n, wr ? WR_LAT : RD_LAT);
        host_req = 1'b0;
        repeat (TURN_EXP) @(posedge clk);
        @(negedge clk);
        check(host_ready == 1'b0, "R9 ready one cycle", int'(host_ready), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(sram_cs_n == 1'b1, "R1 cs after reset", int'(sram_cs_n), 1);
        check(sram_we_n == 1'b1, "R1 we after reset", int'(sram_we_n), 1);
        check(sram_oe_n == 1'b1, "R1 oe after reset", int'(sram_oe_n), 1);
        check(sram_dout_en == 1'b0, "R1 bus released after reset", int'(sram_dout_en), 0);
        check(host_ready == 1'b0, "R1 ready after reset", int'(host_ready), 0);
        rst = 1'b0;
        @(negedge clk);

        // R6 boundary addresses and a middle one
        do_op(1'b1, 19'h00000, 8'hA5, 1'b0);
        do_op(1'b1, 19'h7FFFF, 8'h3C, 1'b0);
        do_op(1'b1, 19'h12345, 8'h5A, 1'b0);
        do_op(1'b0, 19'h12345, 8'h00, 1'b0);
        do_op(1'b0, 19'h00000, 8'h00, 1'b0);
        do_op(1'b0, 19'h7FFFF, 8'h00, 1'b0);

        // R8 inputs changed during an access
        do_op(1'b1, 19'h00101, 8'h22, 1'b0);
        do_op(1'b1, 19'h00100, 8'hC3, 1'b1);
        do_op(1'b0, 19'h00100, 8'h00, 1'b0);
        do_op(1'b0, 19'h00101, 8'h00, 1'b1);
        do_op(1'b0, 19'h00101, 8'h00, 1'b0);

        // Mixed patterns
        for (int i = 0; i < 8; i++)
            do_op(1'b1, 19'(i * 19'h0A0F1), 8'(8'h1 << i) ^ 8'(i), 1'b0);
        for (int i = 7; i >= 0; i--)
            do_op(1'b0, 19'(i * 19'h0A0F1), 8'h00, 1'b0);
        do_op(1'b1, 19'h12345, 8'hFF, 1'b0);
        do_op(1'b0, 19'h12345, 8'h00, 1'b0);

        // R1 reset in the middle of a write
        host_we = 1'b1; host_addr = 19'h55555; host_wdata = 8'h99; host_req = 1'b1;
        @(posedge clk); @(negedge clk);
        host_req = 1'b0;
        @(posedge clk); @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check(sram_cs_n == 1'b1, "R1 cs after mid-write reset", int'(sram_cs_n), 1);
        check(sram_we_n == 1'b1, "R1 we after mid-write reset", int'(sram_we_n), 1);
        check(sram_dout_en == 1'b0, "R1 bus after mid-write reset", int'(sram_dout_en), 0);
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        do_op(1'b0, 19'h00000, 8'h00, 1'b0);

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R9 every access answered", sb_q.size(), 0);
        check(contention == 0, "R7 no bus contention", contention, 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule